// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the control and status register bank of a multi-channel DMA controller. A simple word-wide bus writes and reads three registers. A control register holds the per-channel clock gates, the per-channel reset requests, two bus-burst enables and a block soft-reset trigger. A completion register holds the per-channel command-done status and its interrupt enables. An error register holds the per-channel error status and its interrupt enables. The channel engines report through single-cycle `done_pulse` and `err_pulse` inputs. The bank drives the gate, reset and enable vectors back to the channels, plus one combined interrupt line.

Each register has three addresses. The plain address loads the whole word. The set alias ORs the written ones into the register. The clear alias clears the bits where ones are written. Zeros written to either alias leave the register unchanged. A driver acknowledges a channel by writing its bit to the clear aliases of both status registers.

Top module: `dmacsr_bank`

## Requirements
- R1: After reset the control register reads 0x000000FF: all eight clock-gate bits are 1 and every other bit is 0. The completion and error registers read 0. `irq` is 0, and `gate_en` is 0xFF.
- R2: The register base addresses are 0x00 (control), 0x10 (completion) and 0x20 (error). For each base, offset +0 loads the word, +4 ORs in the written ones and +8 clears the written ones. Zero bits written to +4 or +8 change nothing. A read at +0, +4 or +8 returns the register value.
- R3: Control register layout: bits [7:0] are the clock gates of channels 0..7, driven on `gate_en`. Bit 28 is the peripheral-bus burst enable and bit 29 is the 8-beat system-bus burst enable, driven on `pbus_burst_en` and `sbus_burst8_en`.
- R4: Writing a one to control bit 16+ch through +0 or +4 raises `chan_reset[ch]` in the cycle after the write, for exactly one cycle. These bits always read back as 0 once the pulse has ended.
- R5: Completion register: bit ch is the done status, and bit 16+ch is the interrupt enable, driven on `done_irq_en`. A `done_pulse[ch]` sets the status bit at the next clock edge.
- R6: Error register: bit ch is the error status, and bit 16+ch is its interrupt enable, driven on `err_irq_en`. An `err_pulse[ch]` sets the status bit at the next clock edge.
- R7: When a hardware pulse and a clear-alias write of the same status bit fall in the same cycle, the bit ends up set.
- R8: `irq` is 1 exactly when some channel has both its done status and done enable set, or both its error status and error enable set.
- R9: Clearing a channel's status bits through the +8 aliases drops its contribution to `irq` in the cycle after the write.
- R10: Writing a one to control bit 31 through +0 or +4 returns all three registers to their R1 defaults at that clock edge. The rest of that write's data is ignored.
- R11: The following addresses are unmapped: offset +0xC of any register, base 0x30 and above, and addresses with nonzero low two bits. Writes to them change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| done_pulse | input | 8 | Per-channel command-done pulses |
| err_pulse | input | 8 | Per-channel error pulses |
| gate_en | output | 8 | Per-channel clock gate (1 = gated) |
| chan_reset | output | 8 | Per-channel one-cycle reset pulses |
| sbus_burst8_en | output | 1 | System-bus 8-beat burst enable |
| pbus_burst_en | output | 1 | Peripheral-bus burst enable |
| done_irq_en | output | 8 | Per-channel done interrupt enables |
| err_irq_en | output | 8 | Per-channel error interrupt enables |
| irq | output | 1 | Combined interrupt |

## Verification
The alias logic is tried with four kinds of write: set and clear writes with mixed ones, all-zero writes to both aliases, and a plain write of a new pattern. These separate OR, AND-NOT, no-op and load behaviour. Completion pulses are tried on an enabled channel and on a disabled one, which separates status capture from interrupt gating. A pulse that lands in the same cycle as a clear tests the priority rule. Soft reset is triggered with other data bits set, and writes to offset +0xC and base 0x30 check that those addresses are not mapped onto the real registers.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
   // register index taken from bus_addr[5:4]
   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_DONE = 1;
   localparam int unsigned REG_ERR  = 2;
   localparam int unsigned NREG     = 3;

   // alias taken from bus_addr[3:2]
   typedef enum logic [1:0] {
      ALIAS_LOAD = 2'd0,
      ALIAS_SET  = 2'd1,
      ALIAS_CLR  = 2'd2,
      ALIAS_NONE = 2'd3
   } alias_e;

   // control register bit positions
   localparam int unsigned GATE_LSB   = 0;
   localparam int unsigned CRST_LSB   = 16;
   localparam int unsigned PBURST_BIT = 28;
   localparam int unsigned SBURST_BIT = 29;
   localparam int unsigned SRST_BIT   = 31;
   // status register enable field position
   localparam int unsigned EN_LSB     = 16;
endpackage

// File: rtl/dmacsr_decode.sv
module dmacsr_decode
   import dmacsr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [NREG-1:0]   sel,
   output logic [NREG-1:0]   wr_load,
   output logic [NREG-1:0]   wr_set,
   output logic [NREG-1:0]   wr_clr
);
   logic   in_map;
   alias_e al;

   assign al     = alias_e'(bus_addr[3:2]);
   assign in_map = (bus_addr[1:0] == 2'b00) && (al != ALIAS_NONE) &&
                   (bus_addr[ADDR_W-1:6] == '0);

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      assign sel[r]     = in_map && (bus_addr[5:4] == 2'(r));
      assign wr_load[r] = bus_wr && sel[r] && (al == ALIAS_LOAD);
      assign wr_set[r]  = bus_wr && sel[r] && (al == ALIAS_SET);
      assign wr_clr[r]  = bus_wr && sel[r] && (al == ALIAS_CLR);
   end
endmodule

// File: rtl/dmacsr_field.sv
module dmacsr_field #(
   parameter int unsigned W        = 8,
   parameter logic [W-1:0] RST_VAL = '0,
   parameter bit          SELF_CLR = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_rst,
   input  logic         wr_load,
   input  logic         wr_set,
   input  logic         wr_clr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   if (SELF_CLR) begin : g_pulse
      // bits live for one cycle only; clear alias has nothing to do
      assign nxt = (wr_load || wr_set) ? wdata : '0;
   end else begin : g_hold
      always_comb begin
         if (wr_load)     nxt = wdata;
         else if (wr_set) nxt = q | wdata;
         else if (wr_clr) nxt = q & ~wdata;
         else             nxt = q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= RST_VAL;
      else if (soft_rst) q <= RST_VAL;
      else               q <= nxt | hw_set;
   end
endmodule

// File: rtl/dmacsr_bank.sv
module dmacsr_bank
   import dmacsr_pkg::*;
#(
   parameter int unsigned NCH    = 8,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NCH-1:0]    done_pulse,
   input  logic [NCH-1:0]    err_pulse,
   output logic [NCH-1:0]    gate_en,
   output logic [NCH-1:0]    chan_reset,
   output logic              sbus_burst8_en,
   output logic              pbus_burst_en,
   output logic [NCH-1:0]    done_irq_en,
   output logic [NCH-1:0]    err_irq_en,
   output logic              irq
);
   localparam logic [NCH-1:0] GATE_RST = '1;

   if (NCH < 1 || NCH > 12) begin : g_bad_nch
      $error("dmacsr_bank: NCH must be 1..12");
   end
   if (DATA_W != 32) begin : g_bad_dw
      $error("dmacsr_bank: DATA_W must be 32");
   end
   if (ADDR_W < 7) begin : g_bad_aw
      $error("dmacsr_bank: ADDR_W must be at least 7");
   end

   logic [NREG-1:0] sel, wr_load, wr_set, wr_clr;
   logic            soft_rst;
   logic [1:0]      burst_q;
   logic [NCH-1:0]  done_q, err_q;
   logic [NCH-1:0]  zero_hw;

   assign zero_hw = '0;

   dmacsr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .sel     (sel),
      .wr_load (wr_load),
      .wr_set  (wr_set),
      .wr_clr  (wr_clr)
   );

   assign soft_rst = (wr_load[REG_CTRL] || wr_set[REG_CTRL]) && bus_wdata[SRST_BIT];

   dmacsr_field #(.W(NCH), .RST_VAL(GATE_RST), .SELF_CLR(1'b0)) u_gate (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_load(wr_load[REG_CTRL]), .wr_set(wr_set[REG_CTRL]), .wr_clr(wr_clr[REG_CTRL]),
      .wdata(bus_wdata[GATE_LSB +: NCH]), .hw_set(zero_hw), .q(gate_en)
   );

   dmacsr_field #(.W(NCH), .RST_VAL('0), .SELF_CLR(1'b1)) u_crst (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_load(wr_load[REG_CTRL]), .wr_set(wr_set[REG_CTRL]), .wr_clr(wr_clr[REG_CTRL]),
      .wdata(bus_wdata[CRST_LSB +: NCH]), .hw_set(zero_hw), .q(chan_reset)
   );

   dmacsr_field #(.W(2), .RST_VAL(2'b00), .SELF_CLR(1'b0)) u_burst (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_load(wr_load[REG_CTRL]), .wr_set(wr_set[REG_CTRL]), .wr_clr(wr_clr[REG_CTRL]),
      .wdata({bus_wdata[SBURST_BIT], bus_wdata[PBURST_BIT]}), .hw_set(2'b00), .q(burst_q)
   );

   assign sbus_burst8_en = burst_q[1];
   assign pbus_burst_en  = burst_q[0];

   dmacsr_field #(.W(NCH), .RST_VAL('0), .SELF_CLR(1'b0)) u_done (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_load(wr_load[REG_DONE]), .wr_set(wr_set[REG_DONE]), .wr_clr(wr_clr[REG_DONE]),
      .wdata(bus_wdata[NCH-1:0]), .hw_set(done_pulse), .q(done_q)
   );

   dmacsr_field #(.W(NCH), .RST_VAL('0), .SELF_CLR(1'b0)) u_done_en (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_load(wr_load[REG_DONE]), .wr_set(wr_set[REG_DONE]), .wr_clr(wr_clr[REG_DONE]),
      .wdata(bus_wdata[EN_LSB +: NCH]), .hw_set(zero_hw), .q(done_irq_en)
   );

   dmacsr_field #(.W(NCH), .RST_VAL('0), .SELF_CLR(1'b0)) u_err (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_load(wr_load[REG_ERR]), .wr_set(wr_set[REG_ERR]), .wr_clr(wr_clr[REG_ERR]),
      .wdata(bus_wdata[NCH-1:0]), .hw_set(err_pulse), .q(err_q)
   );

   dmacsr_field #(.W(NCH), .RST_VAL('0), .SELF_CLR(1'b0)) u_err_en (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_load(wr_load[REG_ERR]), .wr_set(wr_set[REG_ERR]), .wr_clr(wr_clr[REG_ERR]),
      .wdata(bus_wdata[EN_LSB +: NCH]), .hw_set(zero_hw), .q(err_irq_en)
   );

   assign irq = |(done_q & done_irq_en) || |(err_q & err_irq_en);

   // read word assembly
   logic [DATA_W-1:0] ctrl_word, done_word, err_word;

   always_comb begin
      ctrl_word = '0;
      ctrl_word[GATE_LSB +: NCH] = gate_en;
      ctrl_word[CRST_LSB +: NCH] = chan_reset;
      ctrl_word[PBURST_BIT]      = pbus_burst_en;
      ctrl_word[SBURST_BIT]      = sbus_burst8_en;
      done_word = '0;
      done_word[NCH-1:0]         = done_q;
      done_word[EN_LSB +: NCH]   = done_irq_en;
      err_word = '0;
      err_word[NCH-1:0]          = err_q;
      err_word[EN_LSB +: NCH]    = err_irq_en;
   end

   always_comb begin
      bus_rdata = '0;
      if (sel[REG_CTRL]) bus_rdata = ctrl_word;
      if (sel[REG_DONE]) bus_rdata = done_word;
      if (sel[REG_ERR])  bus_rdata = err_word;
   end
endmodule

// File: rtl/dmacsr_chk.sv
module dmacsr_chk #(
   parameter int unsigned NCH = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bus_wr,
   input logic           soft_rst,
   input logic [NCH-1:0] done_pulse,
   input logic [NCH-1:0] err_pulse,
   input logic [NCH-1:0] done_q,
   input logic [NCH-1:0] err_q,
   input logic [NCH-1:0] done_irq_en,
   input logic [NCH-1:0] gate_en,
   input logic [NCH-1:0] chan_reset,
   input logic           irq
);
   assert_gate_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(gate_en));

   assert_reset_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_reset != '0 && !bus_wr) |=> chan_reset == '0);

   // covers R7 as well: no clear can win over a pulse
   assert_done_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse != '0 && !soft_rst) |=> ((done_q & $past(done_pulse)) == $past(done_pulse)));

   assert_err_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_pulse != '0 && !soft_rst) |=> ((err_q & $past(err_pulse)) == $past(err_pulse)));

   assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_pulse & done_irq_en) != '0 && !bus_wr) |=> irq);

   assert_soft_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (gate_en == '1 && chan_reset == '0 && !irq));
endmodule

bind dmacsr_bank dmacsr_chk #(.NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .soft_rst   (soft_rst),
   .done_pulse (done_pulse),
   .err_pulse  (err_pulse),
   .done_q     (done_q),
   .err_q      (err_q),
   .done_irq_en(done_irq_en),
   .gate_en    (gate_en),
   .chan_reset (chan_reset),
   .irq        (irq)
);

// File: tb/tb_dmacsr_bank.sv
module tb_dmacsr_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] done_pulse = '0, err_pulse = '0;
   logic [NCH-1:0] gate_en, chan_reset, done_irq_en, err_irq_en;
   logic sbus_burst8_en, pbus_burst_en, irq;

   int n_run = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dmacsr_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .done_pulse(done_pulse), .err_pulse(err_pulse),
      .gate_en(gate_en), .chan_reset(chan_reset),
      .sbus_burst8_en(sbus_burst8_en), .pbus_burst_en(pbus_burst_en),
      .done_irq_en(done_irq_en), .err_irq_en(err_irq_en), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // drive at a falling edge, captured at the next rising edge,
   // returns at the following falling edge with the strobe dropped
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
      @(negedge clk);
      done_pulse = dn; err_pulse = er;
      @(negedge clk);
      done_pulse = '0; err_pulse = '0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h00, v); check("R1 ctrl default", v, 32'h0000_00FF);
      rd(8'h10, v); check("R1 done default", v, 32'h0);
      rd(8'h20, v); check("R1 err default", v, 32'h0);
      check("R1 irq default", {31'b0, irq}, 32'h0);
      check("R1 gate_en default", {24'b0, gate_en}, 32'hFF);
   endtask

   task automatic t_alias();
      logic [31:0] v;
      wr(8'h08, 32'h0000_00F0);
      rd(8'h00, v); check("R2 clear alias", v, 32'h0000_000F);
      wr(8'h04, 32'h0000_0010);
      rd(8'h04, v); check("R2 set alias", v, 32'h0000_001F);
      wr(8'h04, 32'h0);
      wr(8'h08, 32'h0);
      rd(8'h08, v); check("R2 zero writes no effect", v, 32'h0000_001F);
      wr(8'h00, 32'h0000_00A5);
      check("R2 R3 load to gate_en", {24'b0, gate_en}, 32'hA5);
   endtask

   task automatic t_burst();
      logic [31:0] v;
      wr(8'h04, 32'h2000_0000);
      check("R3 sbus burst8", {30'b0, sbus_burst8_en, pbus_burst_en}, 32'h2);
      wr(8'h04, 32'h1000_0000);
      rd(8'h00, v); check("R3 both bursts readback", v, 32'h3000_00A5);
      wr(8'h08, 32'h2000_0000);
      check("R3 pbus only", {30'b0, sbus_burst8_en, pbus_burst_en}, 32'h1);
   endtask

   task automatic t_chan_reset();
      logic [31:0] v;
      wr(8'h04, 32'h0005_0000);
      check("R4 reset pulse high", {24'b0, chan_reset}, 32'h05);
      @(negedge clk);
      check("R4 reset pulse gone", {24'b0, chan_reset}, 32'h0);
      rd(8'h00, v); check("R4 readback", v, 32'h1000_00A5);
   endtask

   task automatic t_done();
      logic [31:0] v;
      wr(8'h14, 32'h0004_0000);
      check("R5 done enable out", {24'b0, done_irq_en}, 32'h04);
      pulse(8'h02, 8'h00);
      check("R8 disabled channel no irq", {31'b0, irq}, 32'h0);
      pulse(8'h04, 8'h00);
      check("R8 enabled channel irq", {31'b0, irq}, 32'h1);
      rd(8'h10, v); check("R5 done readback", v, 32'h0004_0006);
      wr(8'h18, 32'h0000_0004);
      wr(8'h28, 32'h0000_0004);
      check("R9 ack drops irq", {31'b0, irq}, 32'h0);
      rd(8'h10, v); check("R9 only acked bit cleared", v, 32'h0004_0002);
   endtask

   task automatic t_priority();
      logic [31:0] v;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h0000_000A;
      done_pulse = 8'h08;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; done_pulse = '0;
      rd(8'h10, v); check("R7 pulse beats clear", v, 32'h0004_0008);
   endtask

   task automatic t_err();
      logic [31:0] v;
      wr(8'h24, 32'h0020_0000);
      check("R6 err enable out", {24'b0, err_irq_en}, 32'h20);
      pulse(8'h00, 8'h20);
      check("R8 err irq", {31'b0, irq}, 32'h1);
      rd(8'h20, v); check("R6 err readback", v, 32'h0020_0020);
      wr(8'h18, 32'h0000_0020);
      wr(8'h28, 32'h0000_0020);
      check("R9 err ack drops irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_soft();
      logic [31:0] v;
      wr(8'h04, 32'h8005_00F0);
      rd(8'h00, v); check("R10 ctrl default", v, 32'h0000_00FF);
      check("R10 no reset pulse", {24'b0, chan_reset}, 32'h0);
      rd(8'h10, v); check("R10 done default", v, 32'h0);
      rd(8'h20, v); check("R10 err default", v, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(8'h0C, 32'h0);
      rd(8'h00, v); check("R11 offset C ignored", v, 32'h0000_00FF);
      rd(8'h0C, v); check("R11 offset C reads 0", v, 32'h0);
      wr(8'h30, 32'hFFFF_FFFF);
      rd(8'h30, v); check("R11 base 0x30 reads 0", v, 32'h0);
      wr(8'h01, 32'h0);
      rd(8'h00, v); check("R11 misaligned ignored", v, 32'h0000_00FF);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_alias();
      t_burst();
      t_chan_reset();
      t_done();
      t_priority();
      t_err();
      t_soft();
      t_unmapped();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule